// File: doc/BRIEF.md
# Four-Channel Shared-Timebase PWM Generator

This block drives four pulse-width modulated outputs from one common timebase. A programmable clock divider produces a slow local tick, and a single 8-bit period counter steps once per tick, so every period lasts exactly 256 ticks. Each output compares that shared count against its own 8-bit duty value and stays high while the count has not passed the duty value. A channel is therefore high for between 1 and 256 ticks per period, and it can never produce a zero-width pulse.

Software drives the block through a single-cycle register port. It can write and read the four duty registers and one control register. The control register holds the 8-bit divider value, split into two nibbles, and one enable bit shared by all channels. While the enable bit is clear, the outputs are low and the timebase stays parked at zero. Duty and divider updates made while the block runs are held back until the current period ends, so a period is never cut short or stretched partway through.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every output is low and every register reads back as zero.
- R2: The register map is as follows. The duty register of channel n sits at byte address 4*n and holds its value in bits 7:0. The control register sits at 0x50. In the control register, bits 3:0 hold the low nibble of the divider value, bits 14:11 hold the high nibble and bit 9 is the enable. Unused bits read as zero. Any other address reads as zero, and a write to it changes nothing.
- R3: While enabled with divider value P, the shared count advances once every P+1 clocks. A full period therefore lasts 256*(P+1) clocks, and P can be anything from 0 to 255.
- R4: An output is high exactly while the shared count is at or below its active duty value D. This gives a high time of D+1 ticks per period, and D=0 gives a single tick.
- R5: A duty value of 255 keeps the output high for the whole period, with no low cycle between periods.
- R6: While the enable bit is clear, all outputs are low and the count stays at 0. When the enable bit is written to 1, the first clock after that write shows count 0, using the duty and divider values stored at that moment, including a divider value written in the same write.
- R7: A duty write made while the block is enabled leaves the current period unchanged. The new value takes effect from the first tick of the next period.
- R8: A divider write made while the block is enabled leaves the current period unchanged. The new divider rate takes effect from the first tick of the next period.
- R9: Each channel follows only its own duty value; the four outputs share the count and nothing else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Write strobe; the write takes effect on the next rising clock edge |
| regAddr | input | 8 | Byte address of the register to read or write |
| regWdata | input | 32 | Data to write |
| regRdata | output | 32 | Read data for regAddr, available in the same cycle |
| pwmOut | output | 4 | PWM outputs, one per channel |

## Verification
The assertions check these properties on every cycle. The divider count never goes past the active divider value. The shared count holds between ticks and stays at zero while the block is disabled. Every output is high at count zero, and a full-scale duty value never drops. The active duty and divider values change only at a load point.

Some behaviour shows only in the bench scenarios, which measure the output pattern clock by clock against an arithmetic model. These are the exact high time for every duty value, the deferral of mid-period writes to the next period, the period length for divider values that use one nibble or both, and the address decoding on readback.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int CNT_W      = 8;
  localparam int PRE_W      = 8;
  localparam int PRE_HALF   = PRE_W / 2;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int PRE_LO_LSB = 0;
  localparam int PRE_HI_LSB = 11;
  localparam int EN_BIT     = 9;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h50;

  // strobes from control to datapath
  typedef struct packed {
    logic run;   // timebase running
    logic tick;  // local tick this cycle
    logic load;  // take new settings at this edge
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWr,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata,
  input  logic                          atLast,
  output logic [NUM_CH-1:0][CNT_W-1:0]  dutyNext,
  output pwmStrobe_t                    strb
);
  logic [NUM_CH-1:0][CNT_W-1:0] dutyShd;
  logic [PRE_W-1:0]             preShd;
  logic [PRE_W-1:0]             preNext;
  logic [PRE_W-1:0]             prescAct;
  logic [PRE_W-1:0]             divCnt;
  logic                         enReg;
  logic                         ctrlHit;
  logic [NUM_CH-1:0]            dutyHit;
  logic                         tick;
  logic                         load;

  assign ctrlHit = regWr && (regAddr == CTRL_ADDR);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_dec
      assign dutyHit[gi]  = regWr && (regAddr == ADDR_W'(4 * gi));
      assign dutyNext[gi] = dutyHit[gi] ? regWdata[CNT_W-1:0] : dutyShd[gi];
    end
  endgenerate

  assign preNext = ctrlHit ? {regWdata[PRE_HI_LSB +: PRE_HALF], regWdata[PRE_LO_LSB +: PRE_HALF]}
                           : preShd;

  assign tick = enReg && (divCnt == prescAct);
  assign load = !enReg || (tick && atLast);

  assign strb.run  = enReg;
  assign strb.tick = tick;
  assign strb.load = load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyShd  <= '0;
      preShd   <= '0;
      enReg    <= 1'b0;
      prescAct <= '0;
      divCnt   <= '0;
    end else begin
      dutyShd <= dutyNext;
      preShd  <= preNext;
      if (ctrlHit) enReg <= regWdata[EN_BIT];
      if (load) prescAct <= preNext;
      if (!enReg || tick) divCnt <= '0;
      else                divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_ADDR) begin
      regRdata[PRE_LO_LSB +: PRE_HALF] = preShd[PRE_HALF-1:0];
      regRdata[PRE_HI_LSB +: PRE_HALF] = preShd[PRE_W-1:PRE_HALF];
      regRdata[EN_BIT]                 = enReg;
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if (regAddr == ADDR_W'(4 * n)) regRdata[CNT_W-1:0] = dutyShd[n];
    end
  end

  // R3: divider never passes the active value
  a_r3_div_bound: assert property (@(posedge clk) disable iff (!rstN)
    enReg |-> (divCnt <= prescAct));

  // R8: active divider changes only at a period boundary while running
  a_r8_presc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && !(tick && atLast)) |=> $stable(prescAct));
endmodule

// File: rtl/pwm_quad_datapath.sv
module pwm_quad_datapath
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pwmStrobe_t                    strb,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  dutyNext,
  output logic                          atLast,
  output logic [NUM_CH-1:0]             pwmOut
);
  logic [CNT_W-1:0]             cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] dutyAct;

  assign atLast = (cnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dutyAct <= '0;
    end else begin
      if (strb.load) dutyAct <= dutyNext;
      if (!strb.run)      cnt <= '0;
      else if (strb.tick) cnt <= cnt + 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      assign pwmOut[gi] = strb.run && (cnt <= dutyAct[gi]);

      // R5: full scale never drops
      a_r5_full: assert property (@(posedge clk) disable iff (!rstN)
        (strb.run && dutyAct[gi] == '1) |-> pwmOut[gi]);
    end
  endgenerate

  // R6: count parked while disabled
  a_r6_count_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (cnt == '0));

  // R3: count moves only on a tick
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.tick) |=> $stable(cnt));

  // R4: every channel is high on count zero
  a_r4_first_tick: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && cnt == '0) |-> (&pwmOut));

  // R7: active duties change only at a load point
  a_r7_duty_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(dutyAct));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  pwmStrobe_t                   strb;
  logic                         atLast;
  logic [NUM_CH-1:0][CNT_W-1:0] dutyNext;

  pwm_quad_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .atLast   (atLast),
    .dutyNext (dutyNext),
    .strb     (strb)
  );

  pwm_quad_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dutyNext (dutyNext),
    .atLast   (atLast),
    .pwmOut   (pwmOut)
  );
endmodule

// File: tb/pwm_quad_tb.sv
module pwm_quad_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  pwmOut;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pwm_quad u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pwmOut(pwmOut)
  );

  function automatic logic [31:0] ctrlWord(input int p, input bit en);
    logic [31:0] w;
    w = '0;
    w[3:0]   = 4'(p);
    w[14:11] = 4'(p >> 4);
    w[9]     = en;
    return w;
  endfunction

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1 regWr = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 checkVal(req, regRdata, exp);
  endtask

  task automatic startRun(input int p, input logic [3:0][7:0] d);
    writeReg(8'h50, 32'h0);
    for (int n = 0; n < 4; n++) writeReg(8'(4 * n), {24'h0, d[n]});
    writeReg(8'h50, ctrlWord(p, 1'b1));
  endtask

  // interval k counts negedges after the enabling edge, starting at 0
  task automatic runCheck(input string req, input int pa, input int pb,
                          input logic [3:0][7:0] dA, input logic [3:0][7:0] dB,
                          input int nCyc, input int wrK, input logic [7:0] wrA,
                          input logic [31:0] wrD, input int offK);
    int len0;
    int c;
    logic [7:0] du;
    len0 = 256 * (pa + 1);
    for (int k = 0; k < nCyc; k++) begin
      @(negedge clk);
      if (k < len0) c = k / (pa + 1);
      else          c = ((k - len0) / (pb + 1)) % 256;
      for (int n = 0; n < 4; n++) begin
        du = (k < len0) ? dA[n] : dB[n];
        if (offK >= 0 && k > offK) checkVal(req, {31'h0, pwmOut[n]}, 32'h0);
        else checkVal(req, {31'h0, pwmOut[n]}, {31'h0, (c <= int'(du))});
      end
      if (k == wrK) begin regWr = 1'b1; regAddr = wrA; regWdata = wrD; end
      if (k == wrK + 1) regWr = 1'b0;
    end
    @(negedge clk);
    regWr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [3:0][7:0] dA;
    logic [3:0][7:0] dB;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    checkVal("R1", {28'h0, pwmOut}, 32'h0);
    readCheck("R1", 8'h50, 32'h0);
    for (int n = 0; n < 4; n++) readCheck("R1", 8'(4 * n), 32'h0);

    // R2 field packing and decoding
    writeReg(8'h50, 32'hFFFF_FFFF);
    readCheck("R2", 8'h50, 32'h0000_7A0F);
    writeReg(8'h50, 32'h0);
    readCheck("R2", 8'h50, 32'h0);
    writeReg(8'h04, 32'hABCD_0123);
    readCheck("R2", 8'h04, 32'h23);
    writeReg(8'h40, 32'hFFFF_FFFF);
    writeReg(8'h4C, 32'hFFFF_FFFF);
    readCheck("R2", 8'h40, 32'h0);
    readCheck("R2", 8'h50, 32'h0);
    for (int n = 0; n < 4; n++) readCheck("R2", 8'(4 * n), (n == 1) ? 32'h23 : 32'h0);

    // R6 outputs low while disabled even at full scale
    for (int n = 0; n < 4; n++) writeReg(8'(4 * n), 32'hFF);
    repeat (5) begin
      @(negedge clk);
      checkVal("R6", {28'h0, pwmOut}, 32'h0);
    end

    // R4 R5 R9 sweep of every duty value, divider 0
    for (int r = 0; r < 64; r++) begin
      for (int n = 0; n < 4; n++) dA[n] = 8'((r + 64 * n) % 256);
      startRun(0, dA);
      runCheck("R4/R5/R9", 0, 0, dA, dA, 256, -1, 8'h0, 32'h0, -1);
    end

    // R3 divider 2, two periods
    dA = {8'd255, 8'd127, 8'd1, 8'd0};
    startRun(2, dA);
    runCheck("R3", 2, 2, dA, dA, 1536, -1, 8'h0, 32'h0, -1);

    // R3 high nibble only (P=0x10)
    dA = {8'd200, 8'd3, 8'd128, 8'd0};
    startRun(16, dA);
    runCheck("R3", 16, 16, dA, dA, 17 * 256 + 60, -1, 8'h0, 32'h0, -1);

    // R3 both nibbles, P=255 (first steps only)
    dA = {8'd2, 8'd0, 8'd1, 8'd0};
    startRun(255, dA);
    runCheck("R3", 255, 255, dA, dA, 800, -1, 8'h0, 32'h0, -1);

    // R7 duty write mid-period waits for next period
    dA = {8'd10, 8'd20, 8'd30, 8'd40};
    dB = {8'd10, 8'd20, 8'd30, 8'd200};
    startRun(0, dA);
    runCheck("R7", 0, 0, dA, dB, 512, 100, 8'h00, 32'hC8, -1);

    // R8 divider write mid-period waits for next period
    dA = {8'd60, 8'd0, 8'd255, 8'd128};
    startRun(0, dA);
    runCheck("R8", 0, 1, dA, dA, 768, 50, 8'h50, ctrlWord(1, 1'b1), -1);

    // R6 disable mid-run, then restart from count 0
    dA = {8'd255, 8'd255, 8'd100, 8'd50};
    startRun(0, dA);
    runCheck("R6", 0, 0, dA, dA, 60, 30, 8'h50, 32'h0, 30);
    writeReg(8'h50, ctrlWord(1, 1'b1));
    runCheck("R6", 1, 1, dA, dA, 520, -1, 8'h0, 32'h0, -1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule